// File: doc/BRIEF.md
# SPI Slave Register Bank Controller

This block is an SPI slave through which an external microcontroller reads and writes a bank of 64 eight-bit configuration registers. The block runs on a system clock. It oversamples the serial clock, the active-low select and the serial data input as plain synchronous inputs. Each transaction starts when select goes low. The first byte shifted in is a command byte. It picks the access kind, the direction and a 6-bit register address. One data byte follows the command byte.

While the command byte is shifted in, the slave returns a status byte on MISO. A two-bit mode field in control register 0x04 selects what that byte carries. Commands that address the frame buffer or the SRAM are decoded and reported on a separate pair of flag outputs. The data phases of those accesses are handled elsewhere.

The bench drives the serial clock slowly relative to the system clock. Each SPI half period lasts several system clock cycles.

Top module: `spi_reg_access`

## Requirements
- R1: Select high returns the slave to the idle state, so a partial byte is discarded. Each high-to-low transition of select starts a fresh command byte.
- R2: Bits travel most significant bit first in both directions, using SPI mode 0. MOSI is sampled on rising SCLK edges and MISO changes on falling SCLK edges. The first MISO bit is present before the first rising edge.
- R3: In the command byte, bit 7 = 1 selects register access. Bit 6 selects read (0) or write (1), and bits 5:0 hold the register address.
- R4: A register write stores the second MOSI byte into the addressed register on the eighth rising edge of that byte. If select rises earlier, no register changes.
- R5: On a register read, the addressed register is returned on MISO during the second byte. MOSI content during that byte has no effect on any register.
- R6: Bits 7:6 of register 0x04 are the status mode. When they are 00, the byte returned during the command byte is zero. Any other value returns the 5-bit status input, zero-extended.
- R7: Command bits 7:5 = 001 or 011 flag a frame-buffer access (memAccess = 2'b01). Values 000 or 010 flag an SRAM access (memAccess = 2'b10). memWrite equals command bit 6. The flags hold until select rises, and no register changes.
- R8: Bytes clocked after the data byte of a register access are ignored, and MISO returns zero during them.
- R9: After reset, all registers are zero, MISO is low and both access flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from the master, idle low |
| csN | input | 1 | Active-low transaction select |
| mosi | input | 1 | Serial data from the master |
| statusIn | input | 5 | Live status value offered in the first MISO byte |
| miso | output | 1 | Serial data to the master |
| memAccess | output | 2 | Buffer access flag: 01 frame buffer, 10 SRAM, 00 none |
| memWrite | output | 1 | Direction of the flagged buffer access (1 = write) |

## Verification
The assertions assume that sclk, csN and mosi change synchronously to the system clock. They also assume that each SCLK level lasts at least two system clock cycles, so every edge is seen exactly once, and that sclk is low whenever select changes. The bench drives all three inputs on falling system clock edges and holds each SCLK level for four cycles. It lowers and raises select only while SCLK is low. Under these conditions, register changes appear only on write strobes, the buffer flags stay one-hot or zero, and the shift state is empty whenever select is high.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic loadStatus; // select just fell: present status byte
    logic loadRead;   // falling edge after command: present read data
    logic loadZero;   // falling edge after a byte: present zero
    logic shiftOut;   // ordinary falling edge: advance MISO
    logic clearOut;   // select high: empty MISO shifter
    logic writeEn;    // commit write data to the register bank
  } spiStrobes_t;

  typedef enum logic [1:0] {
    MEM_NONE = 2'b00,
    MEM_FBUF = 2'b01,
    MEM_SRAM = 2'b10
  } memKind_e;
endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output spiStrobes_t       strobes,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wrData,
  output logic [1:0]        memAccess,
  output logic              memWrite
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);
  localparam int CMD_TOP = DATA_W - 1;

  logic sclkQ, csNQ;
  logic sclkRise, sclkFall, csFall;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0] byteIdx;           // 0 command, 1 data, 2 extra
  logic [DATA_W-2:0] shIn;
  logic [DATA_W-1:0] fullByte;
  logic cmdIsReg, cmdWrite, loadPend, pendRead, byteDone;

  assign sclkRise = sclk & ~sclkQ & ~csN;
  assign sclkFall = ~sclk & sclkQ & ~csN;
  assign csFall   = ~csN & csNQ;
  assign fullByte = {shIn, mosi};
  assign byteDone = sclkRise && (bitCnt == BIT_LAST);
  assign wrData   = fullByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      csNQ  <= 1'b1;
    end else begin
      sclkQ <= sclk;
      csNQ  <= csN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || csN) begin
      bitCnt    <= '0;
      byteIdx   <= '0;
      shIn      <= '0;
      cmdIsReg  <= 1'b0;
      cmdWrite  <= 1'b0;
      addr      <= '0;
      loadPend  <= 1'b0;
      pendRead  <= 1'b0;
      memAccess <= MEM_NONE;
      memWrite  <= 1'b0;
    end else begin
      if (sclkRise) begin
        shIn   <= fullByte[DATA_W-2:0];
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == BIT_LAST) begin
          loadPend <= 1'b1;
          if (byteIdx != 2'd2) byteIdx <= byteIdx + 1'b1;
          if (byteIdx == 2'd0) begin
            cmdIsReg <= fullByte[CMD_TOP];
            cmdWrite <= fullByte[CMD_TOP-1];
            addr     <= fullByte[ADDR_W-1:0];
            pendRead <= fullByte[CMD_TOP] & ~fullByte[CMD_TOP-1];
            if (fullByte[CMD_TOP]) begin
              memAccess <= MEM_NONE;
              memWrite  <= 1'b0;
            end else begin
              memAccess <= fullByte[CMD_TOP-2] ? MEM_FBUF : MEM_SRAM;
              memWrite  <= fullByte[CMD_TOP-1];
            end
          end else begin
            pendRead <= 1'b0;
          end
        end
      end
      if (sclkFall && loadPend) loadPend <= 1'b0;
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.loadStatus = csFall;
    strobes.clearOut   = csN;
    strobes.writeEn    = byteDone && (byteIdx == 2'd1) && cmdIsReg && cmdWrite;
    strobes.loadRead   = sclkFall && loadPend && pendRead;
    strobes.loadZero   = sclkFall && loadPend && !pendRead;
    strobes.shiftOut   = sclkFall && !loadPend;
  end

  // R7
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(memAccess));

  // R7
  flags_not_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memAccess != MEM_NONE) |-> !cmdIsReg);

  // R1
  idle_on_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (bitCnt == '0 && byteIdx == 2'd0 && memAccess == MEM_NONE));
endmodule

// File: rtl/spi_reg_datapath.sv
module spi_reg_datapath
  import spi_reg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 6,
  parameter int STATUS_W  = 5,
  parameter int CTRL_ADDR = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  spiStrobes_t         strobes,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [STATUS_W-1:0] statusIn,
  output logic                miso
);
  localparam int REG_COUNT = 1 << ADDR_W;

  logic [REG_COUNT-1:0][DATA_W-1:0] regFile;
  logic [DATA_W-1:0] misoReg, statusByte, ctrlReg;

  assign ctrlReg    = regFile[CTRL_ADDR];
  assign statusByte = (ctrlReg[DATA_W-1 -: 2] == 2'b00) ? '0
                    : {{(DATA_W-STATUS_W){1'b0}}, statusIn};
  assign miso       = misoReg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regFile <= '0;
    end else if (strobes.writeEn) begin
      regFile[addr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearOut) misoReg <= '0;
    else if (strobes.loadStatus)   misoReg <= statusByte;
    else if (strobes.loadRead)     misoReg <= regFile[addr];
    else if (strobes.loadZero)     misoReg <= '0;
    else if (strobes.shiftOut)     misoReg <= {misoReg[DATA_W-2:0], 1'b0};
  end

  // R4
  write_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.writeEn |=> $stable(regFile));

  // R1
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (misoReg == '0));

  // R4
  write_needs_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeEn |-> !csN);
endmodule

// File: rtl/spi_reg_access.sv
module spi_reg_access
  import spi_reg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 6,
  parameter int STATUS_W  = 5,
  parameter int CTRL_ADDR = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclk,
  input  logic                csN,
  input  logic                mosi,
  input  logic [STATUS_W-1:0] statusIn,
  output logic                miso,
  output logic [1:0]          memAccess,
  output logic                memWrite
);
  spiStrobes_t       strobes;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wrData;

  spi_reg_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .strobes(strobes), .addr(addr), .wrData(wrData),
    .memAccess(memAccess), .memWrite(memWrite)
  );

  spi_reg_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
                     .STATUS_W(STATUS_W), .CTRL_ADDR(CTRL_ADDR)) uData (
    .clk(clk), .rstN(rstN), .csN(csN), .strobes(strobes),
    .addr(addr), .wrData(wrData), .statusIn(statusIn), .miso(miso)
  );
endmodule

// File: tb/tb_spi_reg_access.sv
module tb_spi_reg_access;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN, sclk, csN, mosi, miso, memWrite;
  logic [4:0] statusIn;
  logic [1:0] memAccess;
  logic [7:0] model [64];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spi_reg_access dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .statusIn(statusIn), .miso(miso), .memAccess(memAccess), .memWrite(memWrite)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] statusExp(input logic [4:0] s);
    return (model[4][7:6] != 2'b00) ? {3'b000, s} : 8'h00;
  endfunction

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      waitN(HALF);
      rx = {rx[6:0], miso};
      sclk = 1'b1;
      waitN(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic csLow();
    csN = 1'b0;
    waitN(HALF);
  endtask

  task automatic csHigh();
    waitN(HALF);
    csN = 1'b1;
    waitN(HALF);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat, input int extra,
                      output logic [7:0] rx0, output logic [7:0] rx1,
                      output logic [7:0] rxExtra);
    logic [7:0] r;
    rxExtra = '0;
    csLow();
    spiBits(cmd, 8, rx0);
    spiBits(dat, 8, rx1);
    for (int e = 0; e < extra; e++) begin
      spiBits(8'hA5 ^ 8'(e), 8, r);
      rxExtra = rxExtra | r;
    end
    csHigh();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r0, r1, rx, v;
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; mosi = 1'b0; statusIn = '0;
    for (int a = 0; a < 64; a++) model[a] = 8'h00;
    waitN(5);
    rstN = 1'b1;
    waitN(2);

    // R9 reset state
    chk(miso == 1'b0, "R9 miso", miso, 0);
    chk(memAccess == 2'b00, "R9 memAccess", memAccess, 0);
    statusIn = 5'h15;
    xfer(8'h85, 8'h00, 0, r0, r1, rx);
    chk(r0 == 8'h00, "R6 default status", r0, 0);
    chk(r1 == 8'h00, "R9 register zero", r1, 0);

    // R3 R4 write sweep over all addresses, status observed during command
    for (int a = 0; a < 64; a++) begin
      v = 8'((a * 37 + 11) & 255);
      statusIn = 5'(a);
      xfer({2'b11, 6'(a)}, v, 0, r0, r1, rx);
      chk(r0 == statusExp(5'(a)), "R6 status on write", r0, statusExp(5'(a)));
      model[a] = v;
    end

    // R2 R3 R5 read sweep, MOSI 0xFF during data byte must not disturb anything
    for (int a = 0; a < 64; a++) begin
      statusIn = 5'(a) ^ 5'h0A;
      xfer({2'b10, 6'(a)}, 8'hFF, 0, r0, r1, rx);
      chk(r1 == model[a], "R5 read data", r1, model[a]);
      chk(r0 == statusExp(statusIn), "R6 status on read", r0, statusExp(statusIn));
    end
    for (int a = 0; a < 64; a += 9) begin
      xfer({2'b10, 6'(a)}, 8'h00, 0, r0, r1, rx);
      chk(r1 == model[a], "R5 mosi ignored on read", r1, model[a]);
    end

    // R6 every mode value against every status value
    for (int m = 0; m < 4; m++) begin
      xfer(8'hC4, {2'(m), 6'h2A}, 0, r0, r1, rx);
      model[4] = {2'(m), 6'h2A};
      for (int s = 0; s < 32; s++) begin
        statusIn = 5'(s);
        xfer(8'h89, 8'h00, 0, r0, r1, rx);
        chk(r0 == statusExp(5'(s)), "R6 mode sweep", r0, statusExp(5'(s)));
      end
    end

    // R4 aborted writes at every partial length
    for (int n = 0; n < 8; n++) begin
      csLow();
      spiBits(8'hD4, 8, r0);
      spiBits(~model[20], n, r1);
      csHigh();
      xfer(8'h94, 8'h00, 0, r0, r1, rx);
      chk(r1 == model[20], "R4 abort", r1, model[20]);
    end

    // R1 select rise mid command discards the partial byte
    csLow();
    spiBits(8'h00, 3, r0);
    csHigh();
    xfer(8'hE1, 8'h6B, 0, r0, r1, rx);
    model[33] = 8'h6B;
    xfer(8'hA1, 8'h00, 0, r0, r1, rx);
    chk(r1 == 8'h6B, "R1 resync after partial", r1, 8'h6B);

    // R7 buffer command codes
    for (int c = 0; c < 4; c++) begin
      logic [7:0] cmd;
      logic [1:0] expAcc;
      cmd = {1'b0, 2'(c >> 1) == 2'b01 ? 1'b1 : 1'b0, 1'(c & 1), 5'h0A};
      expAcc = cmd[5] ? 2'b01 : 2'b10;
      csLow();
      spiBits(cmd, 8, r0);
      waitN(1);
      chk(memAccess == expAcc, "R7 access kind", memAccess, expAcc);
      chk(memWrite == cmd[6], "R7 direction", memWrite, cmd[6]);
      spiBits(8'h55, 8, r1);
      chk(memAccess == expAcc, "R7 held", memAccess, expAcc);
      csHigh();
      chk(memAccess == 2'b00, "R7 cleared", memAccess, 0);
      xfer({2'b10, cmd[5:0]}, 8'h00, 0, r0, r1, rx);
      chk(r1 == model[cmd[5:0]], "R7 no register change", r1, model[cmd[5:0]]);
    end

    // R8 extra bytes after write and read
    xfer(8'hDE, 8'h3C, 2, r0, r1, rx);
    model[30] = 8'h3C;
    chk(rx == 8'h00, "R8 extra miso after write", rx, 0);
    xfer(8'h9E, 8'h00, 3, r0, r1, rx);
    chk(r1 == 8'h3C, "R8 extra not stored", r1, 8'h3C);
    chk(rx == 8'h00, "R8 extra miso after read", rx, 0);
    xfer(8'h9F, 8'h00, 0, r0, r1, rx);
    chk(r1 == model[31], "R8 neighbour untouched", r1, model[31]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule